// File: doc/BRIEF.md
# Dual-Bus Synchronous SRAM with Port-to-Port Streaming

This block is a synchronous word memory with two data ports, a processor port (P) and a system port (S). Both ports share one internal data bus. Each word holds eight data bits and one parity bit, so a word is nine bits wide, and the parity bit is stored and moved like any other bit. Each port has a 9-bit data input, a 9-bit data output held in an output latch, an active-low input enable and an active-low output enable. The block drives no pads. Instead, each port reports a drive-enable output, and the surrounding logic uses it to steer its own bus.

Every clock cycle has two sampling points. The address and the two chip selects are captured on the falling edge. The write enable, both input enables and both data inputs are captured on the following rising edge. At that rising edge a decoder selects the kind of cycle and acts on it:

- a read, loading array data into both output latches;
- a write from one port;
- a write from one port that is also streamed into the other port's latch;
- a pure transfer from one port to the other, with the array left untouched;
- a no-op.

The output enables act without a clock. A port drives when its output enable is low and the latched cycle kind lets that port drive.

The decoder is a state machine. Its state is the kind of cycle decoded at the last rising edge:

| State | Entered when (chip selected, sampled at rising edge) |
|-------|------------------------------------------------------|
| ST_IDLE | Reset, or the chip is not selected |
| ST_READ | Write enable high, both input enables high |
| ST_WR_P | Write enable low, only the P input enable low |
| ST_WR_S | Write enable low, only the S input enable low |
| ST_PASS_P | Write enable high, only the P input enable low |
| ST_PASS_S | Write enable high, only the S input enable low |
| ST_NOP | Both input enables low, or write enable low with both input enables high |

Every state can move to every other state at any rising edge. The next state depends only on the sampled pins, not on the current state. The state sets two things:

- **Drive permission.** ST_READ lets both ports drive. ST_WR_P and ST_PASS_P let S drive. ST_WR_S and ST_PASS_S let P drive. ST_IDLE and ST_NOP let neither port drive.
- **Latch loading.** At the edge that enters ST_READ, both latches load array data. At the edge that enters a P-sourced state, the S latch loads the P input. At the edge that enters an S-sourced state, the P latch loads the S input. In every other case the latches hold.

Top module: `dual_bus_sram`

## Requirements
- R1: The address is captured on the falling clock edge. An address change after that edge and before the next rising edge does not affect the cycle.
- R2: Write enable, input enables and data inputs take effect only as sampled at the rising edge. A write intent withdrawn before that edge performs no write, and data changed before that edge is the data stored.
- R3: When the chip is not selected (active-low select = 1, or active-high select = 0, at the falling edge), no word is written and neither drive enable is set in the following cycle.
- R4: A write stores the enabled port's 9-bit input at the captured address. It happens only when write enable is low and exactly one input enable is low.
- R5: Both input enables low, or write enable low with both input enables high, writes nothing and leaves both drive enables low.
- R6: A read (write enable high, both input enables high) presents the stored word on each port after the rising edge. It drives the P port only, the S port only, or both, according to which output enables are low.
- R7: A port whose input enable was sampled low never drives in that cycle, even with its output enable low.
- R8: In a write with streaming, the word written from one port also appears on the other port's data output. That port drives when its output enable is low.
- R9: With write enable high and exactly one input enable low, the input word moves to the other port's output and the array is not written.
- R10: After reset both data outputs read 0 and neither drive enable is set until the first read or transfer cycle.
- R11: The output enables act without a clock edge. Raising or lowering an output enable changes that port's drive enable within the same clock phase.
- R12: In cycles that load neither latch (no-op, deselect), both data outputs hold their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; falling edge samples address and selects, rising edge samples the rest |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| ce_n | input | 1 | Active-low chip select |
| ce | input | 1 | Active-high chip select |
| we_n | input | 1 | Active-low write enable |
| p_ie_n | input | 1 | P port input enable, active low |
| s_ie_n | input | 1 | S port input enable, active low |
| p_oe_n | input | 1 | P port output enable, active low, unclocked |
| s_oe_n | input | 1 | S port output enable, active low, unclocked |
| p_din | input | DATA_W | P port input word (parity in the top bit) |
| s_din | input | DATA_W | S port input word (parity in the top bit) |
| p_dout | output | DATA_W | P port output latch |
| p_drv | output | 1 | P port drive enable |
| s_dout | output | DATA_W | S port output latch |
| s_drv | output | 1 | S port drive enable |

## Verification
The hardest cases to reach are those that depend on the two clock edges sampling different inputs. These include an address swapped between the falling and rising edge, and a write intent withdrawn in the low phase. They cannot be reached by setting all inputs once per cycle. The stimulus for these tests re-drives selected inputs one nanosecond after the falling edge, so that each edge sees a different value. It then reads the affected addresses back to confirm which value was used. The unsupported combinations, where a port has both its input enable and its output enable low, are also driven on purpose, and that port's drive enable must stay low.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

    // Kind of cycle decoded at the last rising edge.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WR_P,
        ST_WR_S,
        ST_PASS_P,
        ST_PASS_S,
        ST_NOP
    } cyc_state_e;

    // What an output latch takes at a rising edge.
    typedef enum logic [1:0] {
        LD_HOLD,
        LD_ARRAY,
        LD_PEER
    } latch_src_e;

endpackage

// File: rtl/dbs_front.sv
module dbs_front #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              ce,
    output logic [ADDR_W-1:0] addr_q,
    output logic              sel_q
);

    // Address and chip selects are taken on the falling edge.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            sel_q  <= 1'b0;
        end else begin
            addr_q <= addr;
            sel_q  <= ~ce_n & ce;
        end
    end

endmodule

// File: rtl/dbs_array.sv
module dbs_array #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 1024,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/dbs_ctrl.sv
module dbs_ctrl
    import dbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_q,
    input  logic       we_n,
    input  logic       p_ie_n,
    input  logic       s_ie_n,
    output logic       wr_en,
    output logic       wr_from_s,
    output latch_src_e p_src,
    output latch_src_e s_src,
    output logic       p_may_drive,
    output logic       s_may_drive
);

    cyc_state_e state_q;
    cyc_state_e state_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Decode of the pins sampled at this rising edge.
    always_comb begin
        state_d = ST_IDLE;
        if (sel_q) begin
            unique case ({p_ie_n, s_ie_n})
                2'b11:   state_d = we_n ? ST_READ   : ST_NOP;
                2'b01:   state_d = we_n ? ST_PASS_P : ST_WR_P;
                2'b10:   state_d = we_n ? ST_PASS_S : ST_WR_S;
                default: state_d = ST_NOP;
            endcase
        end
    end

    // Outputs: edge actions come from the state being entered,
    // drive permission comes from the state already held.
    always_comb begin
        wr_en       = 1'b0;
        wr_from_s   = 1'b0;
        p_src       = LD_HOLD;
        s_src       = LD_HOLD;
        p_may_drive = 1'b0;
        s_may_drive = 1'b0;

        unique case (state_d)
            ST_READ: begin
                p_src = LD_ARRAY;
                s_src = LD_ARRAY;
            end
            ST_WR_P: begin
                wr_en = 1'b1;
                s_src = LD_PEER;
            end
            ST_WR_S: begin
                wr_en     = 1'b1;
                wr_from_s = 1'b1;
                p_src     = LD_PEER;
            end
            ST_PASS_P: s_src = LD_PEER;
            ST_PASS_S: p_src = LD_PEER;
            default: ;
        endcase

        unique case (state_q)
            ST_READ: begin
                p_may_drive = 1'b1;
                s_may_drive = 1'b1;
            end
            ST_WR_P, ST_PASS_P: s_may_drive = 1'b1;
            ST_WR_S, ST_PASS_S: p_may_drive = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/dbs_port.sv
module dbs_port
    import dbs_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  latch_src_e        src,
    input  logic [DATA_W-1:0] arr_data,
    input  logic [DATA_W-1:0] peer_data,
    input  logic              may_drive,
    input  logic              oe_n,
    output logic [DATA_W-1:0] dout,
    output logic              drv
);

    logic [DATA_W-1:0] lat_q;

    // Output latch: loads at the rising edge and holds otherwise.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else begin
            unique case (src)
                LD_ARRAY: lat_q <= arr_data;
                LD_PEER:  lat_q <= peer_data;
                default:  ;
            endcase
        end
    end

    assign dout = lat_q;
    assign drv  = may_drive & ~oe_n;

endmodule

// File: rtl/dual_bus_sram.sv
module dual_bus_sram
    import dbs_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 1024,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              ce,
    input  logic              we_n,
    input  logic              p_ie_n,
    input  logic              s_ie_n,
    input  logic              p_oe_n,
    input  logic              s_oe_n,
    input  logic [DATA_W-1:0] p_din,
    input  logic [DATA_W-1:0] s_din,
    output logic [DATA_W-1:0] p_dout,
    output logic              p_drv,
    output logic [DATA_W-1:0] s_dout,
    output logic              s_drv
);

    logic [ADDR_W-1:0] addr_q;
    logic              sel_q;
    logic              wr_en;
    logic              wr_from_s;
    latch_src_e        p_src;
    latch_src_e        s_src;
    logic              p_may_drive;
    logic              s_may_drive;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] rdata;

    dbs_front #(.ADDR_W(ADDR_W)) u_front (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (addr),
        .ce_n   (ce_n),
        .ce     (ce),
        .addr_q (addr_q),
        .sel_q  (sel_q)
    );

    dbs_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_q       (sel_q),
        .we_n        (we_n),
        .p_ie_n      (p_ie_n),
        .s_ie_n      (s_ie_n),
        .wr_en       (wr_en),
        .wr_from_s   (wr_from_s),
        .p_src       (p_src),
        .s_src       (s_src),
        .p_may_drive (p_may_drive),
        .s_may_drive (s_may_drive)
    );

    assign wdata = wr_from_s ? s_din : p_din;

    dbs_array #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_array (
        .clk   (clk),
        .wr_en (wr_en),
        .addr  (addr_q),
        .wdata (wdata),
        .rdata (rdata)
    );

    dbs_port #(.DATA_W(DATA_W)) u_pport (
        .clk       (clk),
        .rst_n     (rst_n),
        .src       (p_src),
        .arr_data  (rdata),
        .peer_data (s_din),
        .may_drive (p_may_drive),
        .oe_n      (p_oe_n),
        .dout      (p_dout),
        .drv       (p_drv)
    );

    dbs_port #(.DATA_W(DATA_W)) u_sport (
        .clk       (clk),
        .rst_n     (rst_n),
        .src       (s_src),
        .arr_data  (rdata),
        .peer_data (p_din),
        .may_drive (s_may_drive),
        .oe_n      (s_oe_n),
        .dout      (s_dout),
        .drv       (s_drv)
    );

endmodule

// File: rtl/dual_bus_sram_chk.sv
module dual_bus_sram_chk #(
    parameter int DATA_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_q,
    input logic              wr_en,
    input logic              we_n,
    input logic              p_ie_n,
    input logic              s_ie_n,
    input logic [DATA_W-1:0] p_din,
    input logic [DATA_W-1:0] p_dout,
    input logic              p_drv,
    input logic [DATA_W-1:0] s_dout,
    input logic              s_drv
);

    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_q |=> (!p_drv && !s_drv)); // R3

    AST_DESEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_q |-> !wr_en); // R3

    AST_WRITE_ONE_IE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (!we_n && (p_ie_n != s_ie_n))); // R4

    AST_BOTH_IE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!p_ie_n && !s_ie_n) |-> !wr_en); // R5

    AST_P_IE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q && !p_ie_n) |=> !p_drv); // R7

    AST_S_IE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q && !s_ie_n) |=> !s_drv); // R7

    AST_WR_STREAM_TO_S: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q && !we_n && !p_ie_n && s_ie_n) |=> (s_dout == $past(p_din))); // R8

    AST_PASS_TO_S: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q && we_n && !p_ie_n && s_ie_n) |=> (s_dout == $past(p_din))); // R9

    AST_NOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q && !p_ie_n && !s_ie_n) |=> ($stable(p_dout) && $stable(s_dout))); // R12

endmodule

bind dual_bus_sram dual_bus_sram_chk #(.DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_q  (sel_q),
    .wr_en  (wr_en),
    .we_n   (we_n),
    .p_ie_n (p_ie_n),
    .s_ie_n (s_ie_n),
    .p_din  (p_din),
    .p_dout (p_dout),
    .p_drv  (p_drv),
    .s_dout (s_dout),
    .s_drv  (s_drv)
);

// File: tb/dual_bus_sram_bench.sv
`timescale 1ns/1ps
module dual_bus_sram_bench;

    localparam int DW    = 9;
    localparam int DEPTH = 1024;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          ce_n, ce, we_n, p_ie_n, s_ie_n, p_oe_n, s_oe_n;
    logic [DW-1:0] p_din, s_din;
    logic [DW-1:0] p_dout, s_dout;
    logic          p_drv, s_drv;

    int n_chk = 0;
    int n_err = 0;
    logic [DW-1:0] model [DEPTH];

    always #4 clk = ~clk;

    dual_bus_sram #(.DATA_W(DW), .DEPTH(DEPTH)) u_dual_bus_sram (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .ce(ce),
        .we_n(we_n), .p_ie_n(p_ie_n), .s_ie_n(s_ie_n),
        .p_oe_n(p_oe_n), .s_oe_n(s_oe_n), .p_din(p_din), .s_din(s_din),
        .p_dout(p_dout), .p_drv(p_drv), .s_dout(s_dout), .s_drv(s_drv)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    // Sets every input, then moves to 1 ns after the next rising edge.
    task automatic op(input logic [AW-1:0] a, input logic sel, input logic we,
                      input logic pie, input logic sie, input logic poe,
                      input logic soe, input logic [DW-1:0] pd,
                      input logic [DW-1:0] sd);
        addr = a; ce_n = ~sel; ce = sel; we_n = we;
        p_ie_n = pie; s_ie_n = sie; p_oe_n = poe; s_oe_n = soe;
        p_din = pd; s_din = sd;
        @(posedge clk); #1;
    endtask

    task automatic wr_p(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic soe);
        op(a, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, soe, d, '0);
        model[a] = d;
    endtask

    task automatic wr_s(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic poe);
        op(a, 1'b1, 1'b0, 1'b1, 1'b0, poe, 1'b0, '0, d);
        model[a] = d;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic poe, input logic soe);
        op(a, 1'b1, 1'b1, 1'b1, 1'b1, poe, soe, '0, '0);
    endtask

    task automatic t_reset();
        check("R10", "p_drv after reset", p_drv, 0);
        check("R10", "s_drv after reset", s_drv, 0);
        check("R10", "p_dout after reset", p_dout, 0);
        check("R10", "s_dout after reset", s_dout, 0);
        op(5, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 9'h1FF, 9'h1FF);
        check("R10", "p_drv after no-op", p_drv, 0);
        check("R10", "s_drv after no-op", s_drv, 0);
    endtask

    task automatic t_write_read();
        wr_p(3, 9'h1A5, 1'b1);
        check("R7", "P silent while P writes", p_drv, 0);
        check("R4", "S silent, oe high", s_drv, 0);
        wr_s(7, 9'h05A, 1'b1);
        check("R7", "S silent while S writes", s_drv, 0);
        rd(3, 1'b0, 1'b1);
        check("R6", "P read data", p_dout, model[3]);
        check("R6", "P drives", p_drv, 1);
        check("R6", "S not driving", s_drv, 0);
        rd(7, 1'b0, 1'b0);
        check("R6", "dual read P", p_dout, model[7]);
        check("R6", "dual read S", s_dout, model[7]);
        check("R6", "dual drive", {p_drv, s_drv}, 2'b11);
        rd(3, 1'b1, 1'b0);
        check("R6", "S only read", s_dout, model[3]);
        check("R6", "S only drive", {p_drv, s_drv}, 2'b01);
    endtask

    task automatic t_oe_async();
        p_oe_n = 1'b0; #1;
        check("R11", "P drive rises without edge", p_drv, 1);
        s_oe_n = 1'b1; #1;
        check("R11", "S drive falls without edge", s_drv, 0);
    endtask

    task automatic t_write_stream();
        wr_p(10, 9'h0C3, 1'b0);
        check("R8", "streamed to S", s_dout, 9'h0C3);
        check("R8", "S drives streamed word", s_drv, 1);
        check("R7", "P silent despite oe low", p_drv, 0);
        wr_s(11, 9'h13C, 1'b0);
        check("R8", "streamed to P", p_dout, 9'h13C);
        check("R7", "S silent despite oe low", s_drv, 0);
        rd(10, 1'b0, 1'b1);
        check("R4", "stored from P", p_dout, model[10]);
        rd(11, 1'b0, 1'b1);
        check("R4", "stored from S", p_dout, model[11]);
    endtask

    task automatic t_pass();
        op(3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, '0, 9'h0F0);
        check("R9", "S to P transfer", p_dout, 9'h0F0);
        check("R9", "P drives transfer", p_drv, 1);
        op(7, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 9'h111, '0);
        check("R9", "P to S transfer", s_dout, 9'h111);
        rd(3, 1'b0, 1'b1);
        check("R9", "array kept at 3", p_dout, model[3]);
        rd(7, 1'b0, 1'b1);
        check("R9", "array kept at 7", p_dout, model[7]);
    endtask

    task automatic t_nop();
        rd(10, 1'b0, 1'b0);
        op(10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h1FF, 9'h1EE);
        check("R5", "both ie low: no drive", {p_drv, s_drv}, 2'b00);
        check("R12", "P held", p_dout, model[10]);
        check("R12", "S held", s_dout, model[10]);
        op(10, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 9'h1FF, 9'h1EE);
        check("R5", "we low, ie high: no drive", {p_drv, s_drv}, 2'b00);
        rd(10, 1'b0, 1'b1);
        check("R5", "no write happened", p_dout, model[10]);
    endtask

    task automatic t_deselect();
        addr = 3; ce_n = 1'b1; ce = 1'b1; we_n = 1'b0; p_ie_n = 1'b0; s_ie_n = 1'b1;
        p_oe_n = 1'b0; s_oe_n = 1'b0; p_din = 9'h0AA; s_din = '0;
        @(posedge clk); #1;
        check("R3", "low select off: no drive", {p_drv, s_drv}, 2'b00);
        check("R12", "latch held when deselected", p_dout, model[10]);
        ce_n = 1'b0; ce = 1'b0;
        @(posedge clk); #1;
        check("R3", "high select off: no drive", {p_drv, s_drv}, 2'b00);
        rd(3, 1'b0, 1'b1);
        check("R3", "no write while deselected", p_dout, model[3]);
    endtask

    task automatic t_addr_edge();
        wr_p(21, 9'h022, 1'b1);
        addr = 20; ce_n = 1'b0; ce = 1'b1; we_n = 1'b0; p_ie_n = 1'b0; s_ie_n = 1'b1;
        p_oe_n = 1'b1; s_oe_n = 1'b1; p_din = 9'h155;
        @(negedge clk); #1;
        addr = 21;
        @(posedge clk); #1;
        model[20] = 9'h155;
        rd(20, 1'b0, 1'b1);
        check("R1", "write used falling-edge address", p_dout, model[20]);
        rd(21, 1'b0, 1'b1);
        check("R1", "late address untouched", p_dout, model[21]);
    endtask

    task automatic t_ctrl_edge();
        addr = 21; ce_n = 1'b0; ce = 1'b1; we_n = 1'b0; p_ie_n = 1'b0; s_ie_n = 1'b1;
        p_oe_n = 1'b0; s_oe_n = 1'b1; p_din = 9'h1EE;
        @(negedge clk); #1;
        we_n = 1'b1; p_ie_n = 1'b1;
        @(posedge clk); #1;
        check("R2", "withdrawn write became read", p_dout, model[21]);
        check("R2", "read drives P", p_drv, 1);
        wr_p(22, 9'h100, 1'b1);
        rd(22, 1'b0, 1'b1);
        check("R4", "baseline write at 22", p_dout, 9'h100);
        addr = 22; we_n = 1'b0; p_ie_n = 1'b0; p_oe_n = 1'b1; p_din = 9'h100;
        @(negedge clk); #1;
        p_din = 9'h0FF;
        @(posedge clk); #1;
        model[22] = 9'h0FF;
        rd(22, 1'b0, 1'b1);
        check("R2", "data taken at rising edge", p_dout, model[22]);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        rst_n = 1'b0;
        addr = '0; ce_n = 1'b1; ce = 1'b0; we_n = 1'b1; p_ie_n = 1'b1; s_ie_n = 1'b1;
        p_oe_n = 1'b1; s_oe_n = 1'b1; p_din = '0; s_din = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_write_read();
        t_oe_async();
        t_write_stream();
        t_pass();
        t_nop();
        t_deselect();
        t_addr_edge();
        t_ctrl_edge();
        op(0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, '0, '0);
        summary();
    end

endmodule